// File: doc/BRIEF.md
# Compact Operate/Branch Microprogram Sequencer

This block steps through a small control store of 9-bit microinstructions and drives seven datapath control lines. Each word carries a 2-bit select code and a 7-bit field. The select code decides how the 7-bit field is used. In an operate word the field goes straight out as the control lines. In a branch word the field is a target micro-address, and the control lines stay low. Using one field for both jobs makes a six-word store 54 bits wide instead of 72.

The store is filled from a parameter image whenever reset is high, so no path exists for writing it at run time. The default image is a repeated-addition 4x4 multiply loop. That loop loads the operands, clears the product, then adds and decrements until the datapath's zero flag rises, stores the product and parks on a self-jump. Reset also loads the micro-address from the start-address input. The block has no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `uop_sequencer`

## Requirements
- R1: While `rst` is high, each rising clock edge loads `uaddr` from `start_addr` and refills the store from the image. After reset, `ctrl` and `halted` reflect the word at that address.
- R2: A word's select code is bits 8:7 and its field is bits 6:0, with field bit i driving `ctrl[i]`. Select 00 (operate) puts the field on `ctrl`. The next address is `uaddr`+1, and it wraps from DEPTH-1 to 0.
- R3: Select 01 is a conditional branch with `ctrl` all zero. When `zero` is 0 the next address is the field's low address bits. When `zero` is 1 the address increments.
- R4: Select 10 is an unconditional branch with `ctrl` all zero, and the next address is the field's low address bits whatever `zero` is. The field bits above the address width are 0, and the target is below DEPTH.
- R5: Select 11 is reserved. It behaves as an operate word with `ctrl` forced to zero, and the address increments.
- R6: `halted` is high exactly when the current word is select 10 and its target equals `uaddr`. While halted, `uaddr` holds and `ctrl` is zero.
- R7: With the default image, start address 0 and a datapath that obeys the control lines, the stored product equals the low 4 bits of a*b for all 256 operand pairs. The control lines are: bit0 load multiplicand, bit1 load counter, bit2 clear product, bit3 add, bit4 decrement, bit5 store result.
- R8: With the default image, `halted` rises 2k+3 clock edges after reset is released, where k is the multiplier, or 16 when the multiplier is 0. The count strictly grows for multipliers 1 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; loads start address and store image |
| start_addr | input | ADDR_W (3) | Micro-address taken during reset |
| zero | input | 1 | Datapath zero flag tested by conditional branches |
| ctrl | output | 7 | Datapath control lines, zero on any non-operate word |
| uaddr | output | ADDR_W (3) | Address of the microinstruction now executing |
| halted | output | 1 | Current word is a jump to its own address |

## Verification
The bench goes after the places where the two meanings of the shared field could leak into each other. If branch words let their target bits through to `ctrl`, the datapath would see spurious loads and adds. If the conditional branch had its polarity reversed, the multiply loop would exit after one pass and products would be wrong for every multiplier above 1. A multiplier of zero has to run sixteen loop passes and still give a zero product. Increment wrap at the last store address and the reserved select code are tried with a second instance holding a test image. A design that sent those words to address DEPTH or leaked the field would fall off the traced path.

// File: rtl/uop_seq_pkg.sv
package uop_seq_pkg;

  localparam int SEL_W   = 2;
  localparam int FIELD_W = 7;
  localparam int WORD_W  = SEL_W + FIELD_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_OPERATE = 2'b00,
    SEL_BR_NZ   = 2'b01,
    SEL_JUMP    = 2'b10,
    SEL_RSVD    = 2'b11
  } sel_e;

  typedef struct packed {
    sel_e               sel;
    logic [FIELD_W-1:0] field;
  } uword_t;

  // Repeated-addition multiply image, word 0 in the low bits.
  //  0: load multiplicand + load counter   1: clear product
  //  2: add + decrement                    3: branch to 2 while zero==0
  //  4: store result                       5: jump to self (halt)
  localparam int MUL_DEPTH = 6;
  localparam logic [MUL_DEPTH*WORD_W-1:0] MUL_IMAGE = {
    9'h105, 9'h020, 9'h082, 9'h018, 9'h004, 9'h003
  };

endpackage

// File: rtl/uop_store.sv
module uop_store
  import uop_seq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 3,
  parameter logic [DEPTH*WORD_W-1:0] IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output uword_t            word
);

  uword_t mem [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst) mem[g] <= uword_t'(IMAGE[g*WORD_W +: WORD_W]);
      end
    end
  endgenerate

  // Addresses at or above DEPTH read as an operate word with no lines set.
  always_comb begin
    word = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_addr == ADDR_W'(i)) word = mem[i];
    end
  end

endmodule

// File: rtl/uop_decode.sv
module uop_decode
  import uop_seq_pkg::*;
(
  input  uword_t             word,
  output logic [FIELD_W-1:0] ctrl,
  output logic               is_branch
);

  always_comb begin
    is_branch = (word.sel == SEL_BR_NZ) || (word.sel == SEL_JUMP);
    ctrl      = (word.sel == SEL_OPERATE) ? word.field : '0;
  end

endmodule

// File: rtl/uop_next.sv
module uop_next
  import uop_seq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] cur,
  input  uword_t            word,
  input  logic              zero,
  output logic [ADDR_W-1:0] nxt,
  output logic              self_loop
);

  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] tgt;

  always_comb begin
    inc = (cur == ADDR_W'(DEPTH-1)) ? '0 : cur + ADDR_W'(1);
    tgt = word.field[ADDR_W-1:0];
    unique case (word.sel)
      SEL_BR_NZ: nxt = zero ? inc : tgt;
      SEL_JUMP:  nxt = tgt;
      default:   nxt = inc;
    endcase
    self_loop = (word.sel == SEL_JUMP) && (tgt == cur);
  end

endmodule

// File: rtl/uop_sequencer.sv
module uop_sequencer
  import uop_seq_pkg::*;
#(
  parameter int DEPTH = MUL_DEPTH,
  parameter logic [DEPTH*WORD_W-1:0] IMAGE = MUL_IMAGE,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic               zero,
  output logic [FIELD_W-1:0] ctrl,
  output logic [ADDR_W-1:0]  uaddr,
  output logic               halted
);

  uword_t            cur_word;
  logic [ADDR_W-1:0] mpc;
  logic [ADDR_W-1:0] nxt;
  logic              br_word;
  logic              self_loop;

  uop_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IMAGE(IMAGE)) u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (mpc),
    .word    (cur_word)
  );

  uop_decode u_dec (
    .word      (cur_word),
    .ctrl      (ctrl),
    .is_branch (br_word)
  );

  uop_next #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_next (
    .cur       (mpc),
    .word      (cur_word),
    .zero      (zero),
    .nxt       (nxt),
    .self_loop (self_loop)
  );

  always_ff @(posedge clk) begin
    if (rst) mpc <= start_addr;
    else     mpc <= nxt;
  end

  assign uaddr  = mpc;
  assign halted = self_loop & br_word;

endmodule

// File: rtl/uop_sequencer_chk.sv
module uop_sequencer_chk #(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] start_addr,
  input logic              zero,
  input logic [6:0]        ctrl,
  input logic [ADDR_W-1:0] uaddr,
  input logic              halted,
  input logic [8:0]        cur_word
);

  logic [1:0]        sel;
  logic [6:0]        fld;
  logic [ADDR_W-1:0] step;

  assign sel  = cur_word[8:7];
  assign fld  = cur_word[6:0];
  assign step = (uaddr == ADDR_W'(DEPTH-1)) ? '0 : uaddr + ADDR_W'(1);

  AST_RESET_LOAD: assert property (@(posedge clk)
    rst |=> uaddr == $past(start_addr)); // R1

  AST_OPERATE_STEP: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b00) |=> uaddr == $past(step)); // R2

  AST_OPERATE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b00) |-> ctrl == fld); // R2

  AST_COND_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b01 && !zero) |=> uaddr == $past(fld[ADDR_W-1:0])); // R3

  AST_COND_FALL: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b01 && zero) |=> uaddr == $past(step)); // R3

  AST_BRANCH_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b01 || sel == 2'b10) |-> ctrl == 7'd0); // R4

  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b10) |=> uaddr == $past(fld[ADDR_W-1:0])); // R4

  AST_TARGET_LOW: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b01 || sel == 2'b10) |-> ((fld >> ADDR_W) == 7'd0 && fld < 7'(DEPTH))); // R4

  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b11) |-> ctrl == 7'd0); // R5

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(uaddr))); // R6

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |-> ctrl == 7'd0); // R6

endmodule

bind uop_sequencer uop_sequencer_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_addr (start_addr),
  .zero       (zero),
  .ctrl       (ctrl),
  .uaddr      (uaddr),
  .halted     (halted),
  .cur_word   (cur_word)
);

// File: tb/sim_uop_sequencer.sv
`timescale 1ns/1ps
module sim_uop_sequencer;
  import uop_seq_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] start0 = 3'd0;
  logic [2:0] start1 = 3'd0;
  logic       z1 = 1'b1;
  logic [6:0] ctrl0, ctrl1;
  logic [2:0] addr0, addr1;
  logic       halt0, halt1;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  // Datapath model driven by the control lines of u0.
  logic [3:0] op_a = 4'd0, op_b = 4'd0;
  logic [3:0] xr, cnt, prod, outr;
  logic       zero0;
  assign zero0 = (cnt == 4'd0);

  always @(posedge clk) begin
    if (rst) begin
      outr <= 4'd0;
      cnt  <= 4'd0;
    end else begin
      if (ctrl0[0]) xr <= op_a;
      if (ctrl0[1]) cnt <= op_b;
      if (ctrl0[2]) prod <= 4'd0;
      if (ctrl0[3]) prod <= prod + xr;
      if (ctrl0[4]) cnt <= cnt - 4'd1;
      if (ctrl0[5]) outr <= prod;
    end
  end

  uop_sequencer u0 (
    .clk(clk), .rst(rst), .start_addr(start0), .zero(zero0),
    .ctrl(ctrl0), .uaddr(addr0), .halted(halt0)
  );

  // Test image: 0 reserved, 1 operate 55, 2 cond->0, 3 jump->4, 4 operate 40, 5 operate 01
  localparam logic [6*WORD_W-1:0] TEST_IMAGE = {
    9'h001, 9'h040, 9'h104, 9'h080, 9'h055, 9'h1FF
  };

  uop_sequencer #(.DEPTH(6), .IMAGE(TEST_IMAGE)) u1 (
    .clk(clk), .rst(rst), .start_addr(start1), .zero(z1),
    .ctrl(ctrl1), .uaddr(addr1), .halted(halt1)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {zero driven before edge, expected address, expected ctrl} after one edge
  localparam int NSTEP = 10;
  localparam logic [10:0] TRACE [NSTEP] = '{
    {1'b1, 3'd1, 7'h55},  // R5 reserved word increments; R2 operate drives field
    {1'b1, 3'd2, 7'h00},  // R2 increment, branch word quiet
    {1'b1, 3'd3, 7'h00},  // R3 zero=1 falls through
    {1'b0, 3'd4, 7'h40},  // R4 jump ignores zero
    {1'b0, 3'd5, 7'h01},  // R2
    {1'b0, 3'd0, 7'h00},  // R2 wrap at last address; R5 ctrl zero
    {1'b0, 3'd1, 7'h55},  // R2
    {1'b0, 3'd2, 7'h00},  // R3 branch word quiet
    {1'b0, 3'd0, 7'h00},  // R3 zero=0 taken
    {1'b1, 3'd1, 7'h55}   // R2
  };

  task automatic do_reset(input logic [2:0] s0);
    @(negedge clk);
    rst = 1'b1;
    start0 = s0;
    start1 = 3'd0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    int prev;
    int k;

    do_reset(3'd0);
    // R1 reset state
    chk("R1 u0 addr", addr0, 0);
    chk("R1 u0 ctrl", ctrl0, 7'h03);
    chk("R1 u0 halted", halt0, 0);
    chk("R5 u1 reserved ctrl", ctrl1, 0);
    chk("R1 u1 addr", addr1, 0);

    for (int i = 0; i < NSTEP; i++) begin
      z1 = TRACE[i][10];
      @(negedge clk);
      chk($sformatf("R2-trace step %0d addr", i), addr1, TRACE[i][9:7]);
      chk($sformatf("R2-trace step %0d ctrl", i), ctrl1, TRACE[i][6:0]);
      chk($sformatf("R6 step %0d no halt", i), halt1, 0);
    end

    // R1 start address 5 lands on the halt word: R6
    do_reset(3'd5);
    chk("R1 start addr", addr0, 5);
    chk("R6 halted at self jump", halt0, 1);
    chk("R6 ctrl quiet", ctrl0, 0);
    repeat (3) @(negedge clk);
    chk("R6 address holds", addr0, 5);
    chk("R6 still halted", halt0, 1);

    // R1 reset in mid-run returns to start
    op_a = 4'd3; op_b = 4'd9;
    do_reset(3'd0);
    repeat (4) @(negedge clk);
    do_reset(3'd0);
    chk("R1 mid-run reset addr", addr0, 0);

    // R7 and R8: full operand sweep
    for (int a = 0; a < 16; a++) begin
      prev = 0;
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        op_a = 4'(a);
        op_b = 4'(b);
        do_reset(3'd0);
        cyc = 0;
        while (!halt0 && cyc < 100) begin
          @(negedge clk);
          cyc++;
        end
        k = (b == 0) ? 16 : b;
        chk($sformatf("R7 product %0d*%0d", a, b), outr, (a * b) % 16);
        chk($sformatf("R8 cycles mult %0d", b), cyc, 2 * k + 3);
        if (b >= 2) begin
          total++;
          if (cyc <= prev) begin
            bad++;
            $display("FAIL R8 growth mult %0d: actual=%0d expected>%0d", b, cyc, prev);
          end
        end
        if (b >= 1) prev = cyc;
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule